// File: doc/BRIEF.md
# One-Bit Amplitude Requantizer

This block sits between a polar symbol encoder and a switching power stage. Each accepted sample carries a 2-bit amplitude code and a 3-bit phase code. A first-order noise-shaping loop turns the amplitude code into a single bit. That bit only ever selects "off" or "full output", and there is no intermediate level. Because the loop pushes the requantization error out of band, the in-band noise floor stays where the 2-bit code left it.

The phase code travels through the same single register stage, so each output phase lines up with the amplitude bit of its own sample. When the amplitude bit is 0 the power stage is silent, and the phase output then keeps its previous value rather than toggling for nothing. A sample enters only when its valid flag is high. A cycle without valid leaves the loop and the outputs untouched.

Top module: `amp1_requant`

## Requirements
- R1: While reset is applied, and until the first valid sample has passed through, `out_valid`, `out_amp` and `out_phase` are 0. The loop accumulator restarts at 0.
- R2: `out_valid` is high exactly one clock after a cycle in which `in_valid` was high, and low one clock after a cycle in which it was low.
- R3: For each valid sample with code c, where `in_amp` is the unsigned value 0 to 3, the loop forms s = acc + c. The output bit of that sample is 1 when s >= 2, and the new acc is s - 3 if the bit is 1, otherwise s. The bit appears on `out_amp` one clock after the sample.
- R4: Code 3 always yields an output bit of 1. Code 0 always yields an output bit of 0, from any reachable loop state.
- R5: At a constant code c, the number of ones over any window of 3N consecutive valid samples equals c*N within plus or minus 1.
- R6: When a sample's output bit is 1, `out_phase` in the same output cycle equals that sample's `in_phase`.
- R7: When a sample's output bit is 0, `out_phase` keeps the value it had before that sample.
- R8: A cycle with `in_valid` low changes neither `out_amp`, `out_phase` nor the loop state. The bit sequence after a gap continues exactly as if the gap were absent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample qualifier |
| in_amp | input | 2 | Multi-level amplitude code, 0 to 3 |
| in_phase | input | 3 | Phase code of the sample |
| out_valid | output | 1 | Output sample qualifier |
| out_amp | output | 1 | Requantized amplitude: 0 = off, 1 = full |
| out_phase | output | 3 | Phase code aligned with `out_amp` |

## Verification
A corrupted accumulator does not always show on the very next bit. It shows within at most three valid samples, because the bit sequence departs from the reference model that the bench keeps sample by sample. At a steady code the count of ones drifts outside its window. A misaligned or wrongly held phase register shows on the first output cycle whose amplitude bit is 1, or on the first cycle where a 0 bit is followed by a changed phase. A loop that advances on invalid cycles shows on the first valid sample after a gap.

// File: rtl/amp1_pkg.sv
package amp1_pkg;

  // Highest code of an unsigned w-bit amplitude input.
  function automatic int full_code(input int w);
    return (1 << w) - 1;
  endfunction

  // Decision level of the loop: half of full scale, rounded up.
  function automatic int decide_level(input int w);
    return ((1 << w) - 1 + 1) / 2;
  endfunction

endpackage

// File: rtl/amp1_rst_sync.sv
module amp1_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/amp1_dsm_loop.sv
module amp1_dsm_loop
  import amp1_pkg::*;
#(
  parameter int AMP_W = 2,
  parameter int ACC_W = AMP_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [AMP_W-1:0]        code,
  output logic                    bit_nxt,
  output logic signed [ACC_W-1:0] acc_o
);

  localparam logic signed [ACC_W-1:0] FULL = ACC_W'(full_code(AMP_W));
  localparam logic signed [ACC_W-1:0] THR  = ACC_W'(decide_level(AMP_W));

  logic signed [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum     = acc_q + $signed({{(ACC_W-AMP_W){1'b0}}, code});
    bit_nxt = (sum >= THR);
    acc_d   = acc_q;
    if (en) acc_d = bit_nxt ? (sum - FULL) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/amp1_phase_align.sv
module amp1_phase_align #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            bit_nxt,
  input  logic [PH_W-1:0] phase_in,
  output logic            valid_o,
  output logic            amp_o,
  output logic [PH_W-1:0] phase_o
);

  logic            valid_q, amp_q, amp_d;
  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    amp_d   = amp_q;
    phase_d = phase_q;
    if (en) begin
      amp_d = bit_nxt;
      if (bit_nxt) phase_d = phase_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      amp_q   <= 1'b0;
      phase_q <= '0;
    end else begin
      valid_q <= en;
      amp_q   <= amp_d;
      phase_q <= phase_d;
    end
  end

  assign valid_o = valid_q;
  assign amp_o   = amp_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/amp1_requant.sv
module amp1_requant #(
  parameter int AMP_W  = 2,
  parameter int PH_W   = 3,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [AMP_W-1:0] in_amp,
  input  logic [PH_W-1:0]  in_phase,
  output logic             out_valid,
  output logic             out_amp,
  output logic [PH_W-1:0]  out_phase
);

  localparam int ACC_W = AMP_W + 2;

  logic                    srst_n;
  logic                    bit_nxt;
  logic signed [ACC_W-1:0] acc_s;

  amp1_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  amp1_dsm_loop #(.AMP_W(AMP_W), .ACC_W(ACC_W)) u_loop (
    .clk(clk), .rst_n(srst_n), .en(in_valid), .code(in_amp),
    .bit_nxt(bit_nxt), .acc_o(acc_s)
  );

  amp1_phase_align #(.PH_W(PH_W)) u_align (
    .clk(clk), .rst_n(srst_n), .en(in_valid), .bit_nxt(bit_nxt),
    .phase_in(in_phase), .valid_o(out_valid), .amp_o(out_amp),
    .phase_o(out_phase)
  );

endmodule

// File: rtl/amp1_requant_chk.sv
module amp1_requant_chk
  import amp1_pkg::*;
#(
  parameter int AMP_W = 2,
  parameter int PH_W  = 3,
  parameter int ACC_W = AMP_W + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [AMP_W-1:0]        in_amp,
  input logic [PH_W-1:0]         in_phase,
  input logic                    out_valid,
  input logic                    out_amp,
  input logic [PH_W-1:0]         out_phase,
  input logic signed [ACC_W-1:0] acc
);

  localparam logic [AMP_W-1:0] TOP = AMP_W'(full_code(AMP_W));
  localparam logic signed [ACC_W-1:0] LO = ACC_W'(decide_level(AMP_W) - full_code(AMP_W));
  localparam logic signed [ACC_W-1:0] HI = ACC_W'(decide_level(AMP_W) - 1);

  assert_valid_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_acc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc >= LO) && (acc <= HI));
  assert_full_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_amp == TOP) |=> out_amp);
  assert_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_amp == '0) |=> !out_amp);
  assert_phase_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_amp) |-> (out_phase == $past(in_phase)));
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_amp) |-> $stable(out_phase));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_amp) && $stable(out_phase) && $stable(acc)));

endmodule

bind amp1_requant amp1_requant_chk #(.AMP_W(AMP_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(srst_n), .in_valid(in_valid), .in_amp(in_amp),
  .in_phase(in_phase), .out_valid(out_valid), .out_amp(out_amp),
  .out_phase(out_phase), .acc(acc_s)
);

// File: tb/tb_amp1_requant.sv
module tb_amp1_requant;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_amp = '0;
  logic [2:0] in_phase = '0;
  logic       out_valid, out_amp;
  logic [2:0] out_phase;

  int checks = 0;
  int errors = 0;
  int m_acc = 0;
  logic [2:0] m_phase = '0;
  logic m_amp = 1'b0;

  always #2.5 clk = ~clk;

  amp1_requant dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_amp(in_amp),
    .in_phase(in_phase), .out_valid(out_valid), .out_amp(out_amp),
    .out_phase(out_phase)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply one cycle of input and check the registered result one clock later.
  task automatic step(input bit v, input int code, input int ph);
    in_valid = v;
    in_amp   = 2'(code);
    in_phase = 3'(ph);
    if (v) begin
      int s;
      s = m_acc + code;
      m_amp = (s >= 2);
      m_acc = m_amp ? s - 3 : s;
      if (m_amp) m_phase = 3'(ph);
    end
    @(negedge clk);
    chk(out_valid == v, "R2 valid", out_valid, v);
    chk(out_amp == m_amp, "R3 bit", out_amp, m_amp);
    chk(out_phase == m_phase, "R6/R7 phase", out_phase, m_phase);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    m_acc = 0; m_amp = 1'b0; m_phase = '0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && out_amp == 1'b0 && out_phase == 3'd0,
        "R1 reset", {out_valid, out_amp, out_phase}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_amp == 1'b0 && out_phase == 3'd0,
        "R1 after release", {out_valid, out_amp, out_phase}, 0);
  endtask

  task automatic t_full_and_zero();
    do_reset();
    for (int i = 0; i < 6; i++) begin
      step(1, 3, i);
      chk(out_amp == 1'b1, "R4 code3", out_amp, 1);
      chk(out_phase == 3'(i), "R6 follow", out_phase, i);
    end
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 7 - i);
      chk(out_amp == 1'b0, "R4 code0", out_amp, 0);
      chk(out_phase == 3'd5, "R7 hold", out_phase, 5);
    end
  endtask

  task automatic t_mixed();
    do_reset();
    for (int i = 0; i < 40; i++) step(1, (i * 7 + i / 3) % 4, (i * 5) % 8);
  endtask

  task automatic t_density(input int code);
    int ones;
    for (int i = 0; i < 3; i++) step(1, code, i);
    ones = 0;
    for (int i = 0; i < 30; i++) begin
      step(1, code, i % 8);
      ones += int'(out_amp);
    end
    chk((ones >= code * 10 - 1) && (ones <= code * 10 + 1), "R5 density", ones, code * 10);
  endtask

  task automatic t_gap();
    logic a0;
    logic [2:0] p0;
    do_reset();
    step(1, 1, 3);
    step(1, 2, 6);
    a0 = out_amp; p0 = out_phase;
    for (int i = 0; i < 4; i++) begin
      step(0, 3, 7);
      chk(out_amp == a0 && out_phase == p0, "R8 idle hold", {out_amp, out_phase}, {a0, p0});
    end
    for (int i = 0; i < 9; i++) begin
      step(1, 2, i);
      if (i % 3 == 1) step(0, 0, 2);
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_full_and_zero();
    t_mixed();
    do_reset();
    t_density(1);
    t_density(2);
    t_density(3);
    t_gap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule